// File: doc/BRIEF.md
# ECC Partial-Write Merge Engine

This block takes word writes from a CPU-side port and turns them into column commands for a 32-bit memory data path. Each stored word carries 7 check bits of a single-error-correct, double-error-detect code. A write that enables all four bytes is sent straight to memory with freshly computed check bits. A write with any byte disabled becomes a read-modify-write sequence: the engine reads the stored word and its check bits, repairs a single flipped bit, and replaces only the enabled bytes. It then encodes the merged word again and writes the word and its code back to the same column.

The CPU holds its request until the engine pulses ready. That pulse comes only after the write command for the final word has gone out. The memory side is a plain command port: one command at a time, with a read/write flag, a column, write data and check bits. Read data comes back later with a valid strobe. The latency is nominally two clocks, but the engine waits for the strobe however long it takes. A read that shows an uncorrectable error still completes the write, using the raw stored bytes, and raises an error flag in the cycle of that write.

Top module: `ecc_rmw_merge`

## Requirements
- R1: While reset is active, req_ready_o, mem_cmd_valid_o and err_dbl_o are all low.
- R2: A request with req_be_i = 4'b1111 issues no read. Its write command (mem_cmd_we_o = 1) is issued in the cycle after the request is first seen, and carries req_data_i unchanged.
- R3: A request with any byte enable low issues a read command (mem_cmd_we_o = 0) in the cycle after the request is first seen.
- R4: The merged word takes byte k (bits 8k+7:8k) from req_data_i where req_be_i[k] = 1, and from the stored word otherwise. Its write command is issued in the cycle after mem_rvalid_i is high.
- R5: The check bits are defined as follows. Let p(i) be the i-th integer in 1..38 that is not a power of two, counting from i = 0, so that p(0) = 3. Check bit b (b = 0..5) is the XOR of every data bit i for which bit b of p(i) is set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5.
- R6: When the read word and its check bits hold one flipped bit, the word is repaired before the merge. This applies to a data bit, a check bit or the overall parity bit, and err_dbl_o stays low.
- R7: When the read holds two flipped bits, err_dbl_o is high for exactly the cycle of the write command. The unenabled bytes are taken from the raw read data.
- R8: req_ready_o is a single-cycle pulse in the cycle right after the write command, once per request.
- R9: A request with req_be_i = 4'b0000 still reads the word and writes back the corrected stored word with valid check bits.
- R10: After a read command, no command is issued until mem_rvalid_i arrives, whatever the read latency.
- R11: Both the read and the write command of a request carry req_col_i on mem_col_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request, held until req_ready_o |
| req_col_i | input | COL_W | Target column |
| req_data_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables |
| req_ready_o | output | 1 | One-cycle completion pulse |
| mem_cmd_valid_o | output | 1 | Memory command strobe |
| mem_cmd_we_o | output | 1 | 1 = write, 0 = read |
| mem_col_o | output | COL_W | Command column |
| mem_wdata_o | output | 32 | Write data |
| mem_wecc_o | output | 7 | Write check bits |
| mem_rdata_i | input | 32 | Read data |
| mem_recc_i | input | 7 | Read check bits |
| mem_rvalid_i | input | 1 | Read data valid |
| err_dbl_o | output | 1 | Uncorrectable read error, high with the write command |

## Verification
Take cycle 0 as the cycle in which the request is first driven. For a partial write, the read command is due in cycle 1 and the write in cycle L+2, where L is the read latency of the memory model; ready is due in cycle L+3. A full write has its write command in cycle 1 and ready in cycle 2. Each scenario task samples the outputs on falling edges. It records the cycle number of each command, ready pulse and error pulse, and compares them with these fixed offsets. The memory model is run at a latency of 2 and of 5. The expected data and check bits come from the bench's own code model and byte merge.

// File: rtl/ecc_rmw_pkg.sv
package ecc_rmw_pkg;
  localparam int DATA_W  = 32;
  localparam int BYTES   = DATA_W / 8;
  localparam int HAM_W   = 6;
  localparam int ECC_W   = HAM_W + 1;
  localparam int MAX_POS = DATA_W + HAM_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WAIT, ST_WR, ST_ACK
  } rmw_state_e;

  // codeword position of data bit i (skips power-of-two slots)
  function automatic int unsigned data_pos(input int unsigned i);
    int unsigned n;
    int unsigned res;
    n   = 0;
    res = 0;
    for (int unsigned q = 1; q <= MAX_POS; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (n == i) res = q;
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [ECC_W-1:0] secded_bits(input logic [DATA_W-1:0] d);
    logic [ECC_W-1:0] c;
    int unsigned p;
    c = '0;
    for (int unsigned i = 0; i < DATA_W; i++) begin
      p = data_pos(i);
      for (int b = 0; b < HAM_W; b++)
        if (p[b]) c[b] = c[b] ^ d[i];
    end
    c[HAM_W] = (^d) ^ (^c[HAM_W-1:0]);
    return c;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc import ecc_rmw_pkg::*; (
  input  logic [DATA_W-1:0] data_i,
  output logic [ECC_W-1:0]  ecc_o
);
  assign ecc_o = secded_bits(data_i);
endmodule

// File: rtl/secded_dec.sv
module secded_dec import ecc_rmw_pkg::*; (
  input  logic [DATA_W-1:0] data_i,
  input  logic [ECC_W-1:0]  ecc_i,
  output logic [DATA_W-1:0] data_o,
  output logic              dbl_o
);
  logic [ECC_W-1:0] recalc;
  logic [HAM_W-1:0] syn;
  logic             par;

  assign recalc = secded_bits(data_i);
  assign syn    = recalc[HAM_W-1:0] ^ ecc_i[HAM_W-1:0];
  assign par    = ^{data_i, ecc_i};

  always_comb begin
    data_o = data_i;
    for (int unsigned i = 0; i < DATA_W; i++)
      if (par && (syn == HAM_W'(data_pos(i)))) data_o[i] = ~data_i[i];
  end

  // even parity with nonzero syndrome, or a syndrome past the last slot
  assign dbl_o = (!par && (syn != '0)) || (par && (syn > HAM_W'(MAX_POS)));
endmodule

// File: rtl/byte_merge.sv
module byte_merge #(
  parameter int NB = 4
) (
  input  logic [8*NB-1:0] new_i,
  input  logic [8*NB-1:0] old_i,
  input  logic [NB-1:0]   be_i,
  output logic [8*NB-1:0] out_o
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign out_o[8*k +: 8] = be_i[k] ? new_i[8*k +: 8] : old_i[8*k +: 8];
  end
endmodule

// File: rtl/ecc_rmw_merge.sv
module ecc_rmw_merge import ecc_rmw_pkg::*; #(
  parameter int COL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [BYTES-1:0]  req_be_i,
  output logic              req_ready_o,
  output logic              mem_cmd_valid_o,
  output logic              mem_cmd_we_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ECC_W-1:0]  mem_wecc_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [ECC_W-1:0]  mem_recc_i,
  input  logic              mem_rvalid_i,
  output logic              err_dbl_o
);
  rmw_state_e        state_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdat_q, merged_q;
  logic [BYTES-1:0]  be_q;
  logic              dbl_q;

  logic [DATA_W-1:0] dec_data, merge_out;
  logic              dec_dbl;

  secded_dec u_dec (
    .data_i (mem_rdata_i),
    .ecc_i  (mem_recc_i),
    .data_o (dec_data),
    .dbl_o  (dec_dbl)
  );

  byte_merge #(.NB(BYTES)) u_merge (
    .new_i (wdat_q),
    .old_i (dec_data),
    .be_i  (be_q),
    .out_o (merge_out)
  );

  secded_enc u_enc (
    .data_i (merged_q),
    .ecc_o  (mem_wecc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      col_q    <= '0;
      wdat_q   <= '0;
      merged_q <= '0;
      be_q     <= '0;
      dbl_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          col_q    <= req_col_i;
          wdat_q   <= req_data_i;
          merged_q <= req_data_i;
          be_q     <= req_be_i;
          dbl_q    <= 1'b0;
          state_q  <= (&req_be_i) ? ST_WR : ST_RD;
        end
        ST_RD:   state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          merged_q <= merge_out;
          dbl_q    <= dec_dbl;
          state_q  <= ST_WR;
        end
        ST_WR:   state_q <= ST_ACK;
        ST_ACK: begin
          dbl_q   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_cmd_valid_o = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_cmd_we_o    = (state_q == ST_WR);
  assign mem_col_o       = col_q;
  assign mem_wdata_o     = merged_q;
  assign req_ready_o     = (state_q == ST_ACK);
  assign err_dbl_o       = (state_q == ST_WR) && dbl_q;

  // R8
  ready_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && mem_cmd_we_o) |=> req_ready_o);

  // R8
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);

  // R10
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cmd_valid_o && !mem_cmd_we_o) |=> !mem_cmd_valid_o);

  // R7
  dbl_on_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_dbl_o |-> (mem_cmd_valid_o && mem_cmd_we_o));

  // R6
  corr_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && mem_rvalid_i) |-> ($countones(dec_data ^ mem_rdata_i) <= 1));

  // R2
  full_no_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_valid_i && (&req_be_i)) |=> (mem_cmd_valid_o && mem_cmd_we_o));
endmodule

// File: tb/sim_ecc_rmw_merge.sv
module sim_ecc_rmw_merge;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [3:0]  req_col = '0;
  logic [31:0] req_data = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready;
  logic        cmd_valid, cmd_we;
  logic [3:0]  cmd_col;
  logic [31:0] wdata;
  logic [6:0]  wecc;
  logic [31:0] rdata = '0;
  logic [6:0]  recc = '0;
  logic        rvalid = 0;
  logic        err_dbl;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ecc_rmw_merge #(.COL_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_col_i(req_col), .req_data_i(req_data), .req_be_i(req_be),
    .req_ready_o(req_ready),
    .mem_cmd_valid_o(cmd_valid), .mem_cmd_we_o(cmd_we), .mem_col_o(cmd_col),
    .mem_wdata_o(wdata), .mem_wecc_o(wecc),
    .mem_rdata_i(rdata), .mem_recc_i(recc), .mem_rvalid_i(rvalid),
    .err_dbl_o(err_dbl)
  );

  // bench code model
  function automatic logic [6:0] tb_ecc(input logic [31:0] d);
    logic [6:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int b = 0; b < 6; b++)
          if (((p >> b) & 1) == 1) c[b] = c[b] ^ d[k];
        k++;
      end
    end
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  function automatic logic [31:0] tb_merge(input logic [31:0] nw, input logic [31:0] od,
                                           input logic [3:0] be);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = be[k] ? nw[8*k +: 8] : od[8*k +: 8];
    return r;
  endfunction

  // memory model
  logic [31:0] md [16];
  logic [6:0]  me [16];
  logic        inj_we = 0;
  logic [3:0]  inj_col = '0;
  logic [31:0] inj_d = '0;
  logic [6:0]  inj_e = '0;
  int          lat = 2;
  int          cnt;
  logic [3:0]  rd_col;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      cnt    <= 0;
      rd_col <= '0;
    end else begin
      if (inj_we) begin
        md[inj_col] <= inj_d;
        me[inj_col] <= inj_e;
      end
      rvalid <= (cnt == 1);
      if (cnt == 1) begin
        rdata <= md[rd_col];
        recc  <= me[rd_col];
      end
      if (cnt != 0) cnt <= cnt - 1;
      if (cmd_valid && cmd_we) begin
        md[cmd_col] <= wdata;
        me[cmd_col] <= wecc;
      end
      if (cmd_valid && !cmd_we) begin
        rd_col <= cmd_col;
        cnt    <= lat - 1;
      end
    end
  end

  // per-request observations
  int          r_rd_cyc, r_wr_cyc, r_rdy_cyc, r_rdy_cnt, r_ncmd, r_nerr, r_err_wr_cyc;
  logic [31:0] r_wdata;
  logic [6:0]  r_wecc;
  logic [3:0]  r_rcol, r_wcol;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] col, input logic [31:0] d,
                         input logic [31:0] fd, input logic [6:0] fe);
    @(negedge clk);
    inj_we = 1; inj_col = col; inj_d = d ^ fd; inj_e = tb_ecc(d) ^ fe;
    @(negedge clk);
    inj_we = 0;
  endtask

  task automatic run_req(input logic [3:0] col, input logic [31:0] d, input logic [3:0] be);
    r_rd_cyc = -1; r_wr_cyc = -1; r_rdy_cyc = -1; r_rdy_cnt = 0;
    r_ncmd = 0; r_nerr = 0; r_err_wr_cyc = -1;
    r_wdata = '0; r_wecc = '0; r_rcol = '0; r_wcol = '0;
    @(negedge clk);
    req_valid = 1; req_col = col; req_data = d; req_be = be;
    for (int cyc = 1; cyc < 40; cyc++) begin
      @(negedge clk);
      if (cmd_valid) begin
        r_ncmd++;
        if (cmd_we) begin
          r_wr_cyc = cyc; r_wdata = wdata; r_wecc = wecc; r_wcol = cmd_col;
        end else begin
          r_rd_cyc = cyc; r_rcol = cmd_col;
        end
      end
      if (err_dbl) begin
        r_nerr++;
        r_err_wr_cyc = cyc;
      end
      if (req_ready) begin
        r_rdy_cnt++;
        if (r_rdy_cyc < 0) r_rdy_cyc = cyc;
        req_valid = 0;
      end
      if (r_rdy_cyc >= 0 && cyc >= r_rdy_cyc + 2) break;
    end
    req_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd0);
    chk("R1 cmd", 32'(cmd_valid), 32'd0);
    chk("R1 err", 32'(err_dbl), 32'd0);
  endtask

  task automatic t_full(input logic [3:0] col, input logic [31:0] d);
    preload(col, ~d, '0, '0);
    run_req(col, d, 4'hF);
    chk("R2 no read", 32'(r_rd_cyc), 32'hFFFF_FFFF);
    chk("R2 write cycle", 32'(r_wr_cyc), 32'd1);
    chk("R2 data", r_wdata, d);
    chk("R5 full ecc", 32'(r_wecc), 32'(tb_ecc(d)));
    chk("R11 full col", 32'(r_wcol), 32'(col));
    chk("R8 full ready", 32'(r_rdy_cyc), 32'd2);
    chk("R8 full pulses", 32'(r_rdy_cnt), 32'd1);
    chk("R2 cmds", 32'(r_ncmd), 32'd1);
  endtask

  task automatic t_partial(input string tag, input logic [3:0] col, input logic [31:0] od,
                           input logic [31:0] nw, input logic [3:0] be,
                           input logic [31:0] fd, input logic [6:0] fe,
                           input bit dbl, input int l);
    logic [31:0] exp;
    lat = l;
    preload(col, od, fd, fe);
    run_req(col, nw, be);
    exp = tb_merge(nw, dbl ? (od ^ fd) : od, be);
    chk({tag, " R3 read cycle"}, 32'(r_rd_cyc), 32'd1);
    chk({tag, " R11 read col"}, 32'(r_rcol), 32'(col));
    chk({tag, " R11 write col"}, 32'(r_wcol), 32'(col));
    chk({tag, " R10 write cycle"}, 32'(r_wr_cyc), 32'(l + 2));
    chk({tag, " R4 merged data"}, r_wdata, exp);
    chk({tag, " R5 ecc"}, 32'(r_wecc), 32'(tb_ecc(exp)));
    chk({tag, " R8 ready cycle"}, 32'(r_rdy_cyc), 32'(l + 3));
    chk({tag, " R8 ready pulses"}, 32'(r_rdy_cnt), 32'd1);
    chk({tag, " R7 err pulses"}, 32'(r_nerr), dbl ? 32'd1 : 32'd0);
    if (dbl) chk({tag, " R7 err with write"}, 32'(r_err_wr_cyc), 32'(r_wr_cyc));
    chk({tag, " R10 cmd count"}, 32'(r_ncmd), 32'd2);
    lat = 2;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_full(4'd3, 32'hA5A5_1234);
    t_partial("R4 be0001", 4'd5, 32'h1122_3344, 32'hAABB_CCDD, 4'b0001, '0, '0, 0, 2);
    t_partial("R4 be1010", 4'd6, 32'h5566_7788, 32'h99AA_BBCC, 4'b1010, '0, '0, 0, 2);
    t_partial("R4 be0110", 4'd7, 32'hDEAD_BEEF, 32'h0BAD_F00D, 4'b0110, '0, '0, 0, 2);
    t_partial("R4 be1110", 4'd8, 32'h0F0F_0F0F, 32'hF0E1_D2C3, 4'b1110, '0, '0, 0, 2);
    t_partial("R6 data bit", 4'd9, 32'h1357_9BDF, 32'h2468_ACE0, 4'b0011, 32'h0002_0000, '0, 0, 2);
    t_partial("R6 check bit", 4'd10, 32'hCAFE_BABE, 32'h0000_0000, 4'b1000, '0, 7'h08, 0, 2);
    t_partial("R6 parity bit", 4'd11, 32'h8000_0001, 32'hFFFF_FFFF, 4'b0101, '0, 7'h40, 0, 2);
    t_partial("R7 double", 4'd12, 32'h7654_3210, 32'hABCD_EF01, 4'b0010, 32'h2000_0008, '0, 1, 2);
    t_partial("R9 be0000", 4'd13, 32'h3C3C_A5A5, 32'hFFFF_FFFF, 4'b0000, 32'h4000_0000, '0, 0, 2);
    t_partial("R10 lat5", 4'd14, 32'h0102_0304, 32'hF0F0_F0F0, 4'b0100, '0, '0, 0, 5);
    t_full(4'd15, 32'h0000_0000);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule